// File: doc/BRIEF.md
# Lockable Split Cache Way Allocator

This block selects the way that receives the next line fill in a four-way set-associative cache, and it tells the flush logic which ways a software flush may invalidate. Lookups still search every way, so the block only governs allocation. Victim choice is pseudo-random among the ways the current configuration allows. Three controls narrow that set. A lockdown count shields ways from way 0 upward. A forced-load mode steers every fill into one chosen way. A split mode gives the low ways to instruction fills and the high ways to data fills.

The cache controller raises `fill_req` for one cycle per line fill, together with `fill_is_instr`. One cycle later it reads a one-hot `victim_oh` while `victim_valid` is high. A small two-state machine sequences this: `ST_IDLE` (no result pending) and `ST_GRANT` (a victim is presented). The transition `IDLE->GRANT` occurs on `fill_req`. The transition `GRANT->GRANT` occurs on a back-to-back `fill_req`. The transition `GRANT->IDLE` occurs when no request is present. The flush invalidate mask, the uncacheable-instruction flag and the illegal-configuration flag are combinational.

Top module: `way_allocator`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it, `victim_oh` is 0 and `victim_valid` is 0.
- R2: `victim_valid` is 1 in exactly the cycle after a cycle in which `fill_req` was 1. `victim_oh` has at most one bit set, and it is 0 whenever `victim_valid` is 0.
- R3: With `force_load`=0 and `split_en`=0 and `lock_cnt`=n (0 to 3), ways 0..n-1 are locked and the victim is always one of ways n..3. At most three ways can be locked.
- R4: With `force_load`=1, the victim is way `bank_sel`, even if that way is locked, and whatever `split_en` is.
- R5: `instr_uncacheable` equals `force_load`.
- R6: With `split_en`=1, `force_load`=0 and `lock_cnt`=n not 0, instruction fills pick from ways 0..n-1 and data fills pick from ways n..3.
- R7: `illegal_cfg` is 1 exactly when `split_en`=1 and either `force_load`=1 or `lock_cnt`=0.
- R8: An instruction fill with `split_en`=1, `force_load`=0 and `lock_cnt`=0 has no eligible way. It returns `victim_valid`=1 with `victim_oh`=0.
- R9: `flush_inval` is 0 when `flush`=0. When `flush`=1 it is 4'b1111 if `split_en`=1, and otherwise it has bits n..3 set (n = `lock_cnt`).
- R10: A 16-bit Fibonacci LFSR starts at 16'hACE1 while in reset. Out of reset it shifts left on every clock, and its new bit 0 is the XOR of bits 15, 13, 12 and 10. On a fill, the LFSR's low two bits, taken before that edge's shift, give a starting way. The victim is the first eligible way at or above the start, wrapping from 3 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bank_sel | input | 2 | Target way for forced-load mode |
| force_load | input | 1 | Forced-load mode enable |
| lock_cnt | input | 2 | Number of locked ways, counted from way 0 (also the split point) |
| split_en | input | 1 | Split instruction/data allocation enable |
| fill_req | input | 1 | Line fill request, one cycle |
| fill_is_instr | input | 1 | 1 for an instruction fill, 0 for a data fill |
| flush | input | 1 | Software flush strobe |
| victim_oh | output | 4 | One-hot victim way, registered |
| victim_valid | output | 1 | Victim presented this cycle |
| flush_inval | output | 4 | Ways the current flush invalidates |
| instr_uncacheable | output | 1 | Instruction fetches to be treated as uncacheable data fetches |
| illegal_cfg | output | 1 | Control bits form a forbidden combination |

## Verification
A behavioural model in the bench tracks the LFSR and predicts the victim, valid flag and combinational outputs on every cycle. The stimulus sweeps all lock counts in normal mode to separate locked from unlocked ways. It also forces loads into locked and unlocked ways, which shows that forcing overrides lockdown and split. Split fills of both kinds show which side of the split point each class uses, and the illegal split-with-no-lock case yields an empty victim. Back-to-back and isolated requests exercise every state transition. A reset in mid-run confirms that the LFSR sequence restarts from its seed.

// File: rtl/way_alloc_pkg.sv
package way_alloc_pkg;
    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_GRANT = 1'b1
    } alloc_state_e;
endpackage

// File: rtl/wal_lfsr.sv
module wal_lfsr #(
    parameter int              W    = 16,
    parameter logic [W-1:0]    SEED = 16'hACE1,
    parameter logic [W-1:0]    TAPS = 16'hB400
) (
    input  logic         clk,
    input  logic         rst_n,
    output logic [W-1:0] state
);
    logic fb;
    assign fb = ^(state & TAPS);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= SEED;
        else        state <= {state[W-2:0], fb};
    end

    // R10: a maximal sequence never reaches the all-zero state
    assert_lfsr_nonzero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        state != '0);
endmodule

// File: rtl/wal_eligible.sv
module wal_eligible #(
    parameter int NWAYS = 4,
    parameter int IW    = $clog2(NWAYS)
) (
    input  logic [IW-1:0]    bank_sel,
    input  logic             force_load,
    input  logic [IW-1:0]    lock_cnt,
    input  logic             split_en,
    input  logic             is_instr,
    output logic [NWAYS-1:0] elig,
    output logic [NWAYS-1:0] locked,
    output logic [NWAYS-1:0] flush_mask
);
    for (genvar i = 0; i < NWAYS; i++) begin : g_way
        assign locked[i]     = (IW'(i) < lock_cnt);
        assign flush_mask[i] = split_en | ~locked[i];
        always_comb begin
            if (force_load)    elig[i] = (bank_sel == IW'(i));
            else if (split_en) elig[i] = is_instr ? locked[i] : ~locked[i];
            else               elig[i] = ~locked[i];
        end
    end
endmodule

// File: rtl/wal_pick.sv
module wal_pick #(
    parameter int NWAYS = 4,
    parameter int IW    = $clog2(NWAYS)
) (
    input  logic [IW-1:0]    start,
    input  logic [NWAYS-1:0] elig,
    output logic [NWAYS-1:0] pick
);
    logic [IW-1:0] idx;
    always_comb begin
        pick = '0;
        idx  = '0;
        for (int k = NWAYS - 1; k >= 0; k--) begin
            idx = start + IW'(k);
            if (elig[idx]) pick = NWAYS'(1) << idx;
        end
    end
endmodule

// File: rtl/way_allocator.sv
module way_allocator #(
    parameter int          NWAYS     = 4,
    parameter int          LFSR_W    = 16,
    parameter logic [15:0] LFSR_SEED = 16'hACE1,
    parameter logic [15:0] LFSR_TAPS = 16'hB400
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] bank_sel,
    input  logic       force_load,
    input  logic [1:0] lock_cnt,
    input  logic       split_en,
    input  logic       fill_req,
    input  logic       fill_is_instr,
    input  logic       flush,
    output logic [3:0] victim_oh,
    output logic       victim_valid,
    output logic [3:0] flush_inval,
    output logic       instr_uncacheable,
    output logic       illegal_cfg
);
    import way_alloc_pkg::*;
    localparam int IW = $clog2(NWAYS);

    logic [LFSR_W-1:0] lfsr_q;
    logic [NWAYS-1:0]  elig_w, locked_w, fmask_w, pick_w;
    logic [NWAYS-1:0]  victim_q;
    alloc_state_e      state_q, state_d;

    wal_lfsr #(.W(LFSR_W), .SEED(LFSR_SEED), .TAPS(LFSR_TAPS)) u_lfsr (
        .clk(clk), .rst_n(rst_n), .state(lfsr_q));

    wal_eligible #(.NWAYS(NWAYS)) u_elig (
        .bank_sel(bank_sel), .force_load(force_load), .lock_cnt(lock_cnt),
        .split_en(split_en), .is_instr(fill_is_instr),
        .elig(elig_w), .locked(locked_w), .flush_mask(fmask_w));

    wal_pick #(.NWAYS(NWAYS)) u_pick (
        .start(lfsr_q[IW-1:0]), .elig(elig_w), .pick(pick_w));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (fill_req)  state_d = ST_GRANT;
            ST_GRANT: if (!fill_req) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // registered victim
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        victim_q <= '0;
        else if (fill_req) victim_q <= pick_w;
        else               victim_q <= '0;
    end

    // outputs
    always_comb begin
        victim_valid = 1'b0;
        victim_oh    = '0;
        unique case (state_q)
            ST_IDLE:  ;
            ST_GRANT: begin
                victim_valid = 1'b1;
                victim_oh    = victim_q;
            end
            default:  ;
        endcase
        flush_inval       = flush ? fmask_w : '0;
        instr_uncacheable = force_load;
        illegal_cfg       = split_en & (force_load | (lock_cnt == '0));
    end

    assert_victim_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(victim_oh) && (victim_valid || victim_oh == '0));

    assert_valid_follows_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
        fill_req |=> victim_valid);

    assert_victim_eligible_R6: assert property (@(posedge clk) disable iff (!rst_n)
        fill_req |=> (victim_oh & ~$past(elig_w)) == '0);

    assert_victim_found_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_req && elig_w != '0) |=> victim_oh != '0);

    assert_locked_spared_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_req && !force_load && !split_en) |=> (victim_oh & $past(locked_w)) == '0);

    assert_forced_way_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_req && force_load) |=> victim_oh == (4'b0001 << $past(bank_sel)));

    assert_illegal_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (split_en && force_load) |-> illegal_cfg);

    assert_flush_keeps_locked_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!split_en) |-> (flush_inval & locked_w) == '0);
endmodule

// File: tb/way_allocator_test.sv
module way_allocator_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] bank_sel = '0;
    logic       force_load = 1'b0;
    logic [1:0] lock_cnt = '0;
    logic       split_en = 1'b0;
    logic       fill_req = 1'b0;
    logic       fill_is_instr = 1'b0;
    logic       flush = 1'b0;
    logic [3:0] victim_oh;
    logic       victim_valid;
    logic [3:0] flush_inval;
    logic       instr_uncacheable;
    logic       illegal_cfg;

    int checks = 0;
    int failures = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    way_allocator uut (
        .clk(clk), .rst_n(rst_n), .bank_sel(bank_sel), .force_load(force_load),
        .lock_cnt(lock_cnt), .split_en(split_en), .fill_req(fill_req),
        .fill_is_instr(fill_is_instr), .flush(flush), .victim_oh(victim_oh),
        .victim_valid(victim_valid), .flush_inval(flush_inval),
        .instr_uncacheable(instr_uncacheable), .illegal_cfg(illegal_cfg));

    // behavioural model
    logic [15:0] m_lfsr;
    logic [3:0]  m_vic;
    logic        m_val;
    string       m_tag;

    function automatic logic [3:0] allowed(input int bs, input bit f, input int n,
                                           input bit s, input bit instr);
        logic [3:0] r = '0;
        for (int w = 0; w < 4; w++) begin
            if (f)      r[w] = (w == bs);
            else if (s) r[w] = instr ? (w < n) : (w >= n);
            else        r[w] = (w >= n);
        end
        return r;
    endfunction

    function automatic logic [3:0] choose(input logic [15:0] l, input logic [3:0] el);
        for (int k = 0; k < 4; k++) begin
            int w = (int'(l[1:0]) + k) % 4;
            if (el[w]) return 4'(1 << w);
        end
        return 4'b0000;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_lfsr <= 16'hACE1;
            m_vic  <= '0;
            m_val  <= 1'b0;
            m_tag  <= "R1";
        end else begin
            m_val <= fill_req;
            m_vic <= fill_req ? choose(m_lfsr, allowed(bank_sel, force_load, lock_cnt,
                                                      split_en, fill_is_instr)) : 4'b0;
            if (force_load)                             m_tag <= "R4/R10";
            else if (split_en && lock_cnt == 0 && fill_is_instr) m_tag <= "R8";
            else if (split_en)                          m_tag <= "R6/R10";
            else                                        m_tag <= "R3/R10";
            m_lfsr <= {m_lfsr[14:0], m_lfsr[15] ^ m_lfsr[13] ^ m_lfsr[12] ^ m_lfsr[10]};
        end
    end

    task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%b expected=%b t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic check_all(input bool_in_reset);
        logic [3:0] ef;
        if (bool_in_reset) begin
            check("R1 victim_oh", victim_oh, 4'b0);
            check("R1 victim_valid", {3'b0, victim_valid}, 4'b0);
            return;
        end
        check("R2 victim_valid", {3'b0, victim_valid}, {3'b0, m_val});
        check(m_tag, victim_oh, m_vic);
        check("R5 instr_uncacheable", {3'b0, instr_uncacheable}, {3'b0, force_load});
        check("R7 illegal_cfg", {3'b0, illegal_cfg},
              {3'b0, split_en && (force_load || lock_cnt == 0)});
        ef = '0;
        if (flush) for (int w = 0; w < 4; w++) ef[w] = split_en || (w >= lock_cnt);
        check("R9 flush_inval", flush_inval, ef);
    endtask

    task automatic step(input int bs, input bit f, input int n, input bit s,
                        input bit req, input bit instr, input bit fl);
        @(negedge clk);
        check_all(!rst_n);
        bank_sel = 2'(bs); force_load = f; lock_cnt = 2'(n); split_en = s;
        fill_req = req; fill_is_instr = instr; flush = fl;
    endtask

    initial begin : watchdog
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                failures++;
                $display("FAIL watchdog actual=%0d expected<100000", cycles);
                $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
                $finish;
            end
        end
    end

    initial begin
        // R1: reset state
        for (int i = 0; i < 3; i++) step(0, 0, 0, 0, 1, 0, 0);
        @(negedge clk); check_all(1'b1); rst_n = 1'b1; fill_req = 1'b0;
        step(0, 0, 0, 0, 0, 0, 0);
        check("R1 after reset", victim_oh, 4'b0);
        // R3: all lock counts, data and instr fills, back-to-back
        for (int n = 0; n < 4; n++)
            for (int i = 0; i < 8; i++) step(0, 0, n, 0, 1, i[0], i[1]);
        step(0, 0, 0, 0, 0, 0, 0);
        // R4: forced load into locked and unlocked ways, with split too
        for (int b = 0; b < 4; b++) begin
            step(b, 1, 3, 0, 1, 1, 0);
            step(b, 1, 2, 1, 1, 0, 1);
        end
        // R6 / R8: split mode, both fill kinds
        for (int n = 0; n < 4; n++)
            for (int i = 0; i < 6; i++) step(0, 0, n, 1, 1, i[0], 1);
        // R2: isolated requests
        for (int i = 0; i < 6; i++) step(0, 0, 1, 0, i[0], 0, 0);
        // mid-run reset restarts the LFSR (R10)
        @(negedge clk); check_all(1'b0); rst_n = 1'b0;
        step(0, 0, 0, 0, 0, 0, 0);
        @(negedge clk); check_all(1'b1); rst_n = 1'b1;
        // random mix
        for (int i = 0; i < 3000; i++)
            step($urandom % 4, ($urandom % 5) == 0, $urandom % 4, ($urandom % 3) == 0,
                 ($urandom % 10) < 7, $urandom % 2, ($urandom % 4) == 0);
        step(0, 0, 0, 0, 0, 0, 0);
        step(0, 0, 0, 0, 0, 0, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule